// File: doc/BRIEF.md
# Shared Interrupt Line Controller

This block gathers a parameterised set of external interrupt lines (32 by default) and routes them to a small group of interrupt output pins and to one non-maskable output. Every line is conditioned on its own before routing. A two-flop synchroniser brings the line into the clock domain. The line is then read as a level of either polarity, or watched for a single edge of either direction, or for both edges. The result is a per-line pending bit. Lines in level mode follow their conditioned input. Lines in edge mode latch the event until software clears it.

Software controls the block through a simple 32-bit register bus with a select, a write enable, a 12-bit byte address, write data and registered read data. The bus has bit-per-line registers for polarity, trigger mode and dual-edge mode, plus a readable mask and a readable pending vector. The mask is changed only through a set-word and a clear-word, where a 1 bit acts and a 0 bit does nothing. A command word lets software raise or drop the latched edge state of any single line. Each line has its own route word that sends it to a numbered pin, to the non-maskable output, or to both. Each output is the registered OR of every line that is pending, unmasked and routed to it.

Top module: `irq_shared_ctrl`

## Requirements
- R1: With trigger bit 0 (level), a line is pending while its synchronised input equals its polarity bit (1 = active-high, 0 = active-low), and it stops being pending when the input leaves that level.
- R2: With trigger bit 1 and dual bit 0, polarity 1 latches pending on a rising edge and polarity 0 latches it on a falling edge; the opposite edge sets nothing.
- R3: With trigger bit 1 and dual bit 1, both rising and falling edges latch pending, whatever the polarity bit holds.
- R4: A write to offset 0x280 selects the line given in bits 7:0; bit 31 = 1 sets that line's latched edge state and bit 31 = 0 clears it, taking effect at the write edge.
- R5: The mask resets to all zeros (all lines disabled). A write to 0x380 sets the mask bits that are 1 in the data, a write to 0x300 clears them, and zero bits leave the mask unchanged; a line whose mask bit is 0 drives no output.
- R6: Reads return polarity at 0x100, trigger at 0x180, dual at 0x200, mask at 0x400 and pending at 0x480 (bit i = line i), and the route word of line i at 0x500 + 4*i. Read data appears on the clock edge that samples the read.
- R7: A route word with bit 31 = 1 sends the line to the pin numbered in bits 5:0; each pin is the OR of all pending, unmasked lines routed to it; a pin number at or above the pin count drives no pin.
- R8: A route word with bit 30 = 1 sends the line to the non-maskable output, which is the OR of all pending, unmasked lines with that bit set.
- R9: Outputs are registered. A level change on an input reaches a pin 3 clock edges after it is applied, and an edge reaches it after 4. A latched edge stays pending after the input returns, until software clears it.
- R10: A command word at 0x280 whose line number is not below the line count changes nothing, and writes to the read-only mask and pending offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N_LINES | Raw external interrupt lines |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_pin | output | N_PINS | Routed interrupt outputs |
| irq_nmi | output | 1 | Non-maskable interrupt output |

## Verification
Each result has a fixed latency. A level input reaches a pin after three rising edges: two synchroniser stages and the output register. An edge input needs four, because the latch adds one stage. A register write or a command word shows at an output one edge after the write edge, and read data is valid right after the edge that sampled the read. The bench drives every input just after a falling edge and samples one falling edge after the rising edge at which a result is due. The latency checks also sample one edge early and expect the old value.

// File: rtl/irqsc_pkg.sv
package irqsc_pkg;

    localparam int unsigned BUS_AW = 12;

    localparam logic [BUS_AW-1:0] OFS_POL    = 12'h100;
    localparam logic [BUS_AW-1:0] OFS_TRIG   = 12'h180;
    localparam logic [BUS_AW-1:0] OFS_DUAL   = 12'h200;
    localparam logic [BUS_AW-1:0] OFS_SWEDGE = 12'h280;
    localparam logic [BUS_AW-1:0] OFS_MCLR   = 12'h300;
    localparam logic [BUS_AW-1:0] OFS_MSET   = 12'h380;
    localparam logic [BUS_AW-1:0] OFS_MASK   = 12'h400;
    localparam logic [BUS_AW-1:0] OFS_PEND   = 12'h480;
    localparam logic [BUS_AW-1:0] OFS_ROUTE  = 12'h500;

    typedef struct packed {
        logic       to_pin;
        logic       to_nmi;
        logic [5:0] pin;
    } route_t;

    function automatic route_t word_to_route(input logic [31:0] w);
        route_t r;
        r.to_pin = w[31];
        r.to_nmi = w[30];
        r.pin    = w[5:0];
        return r;
    endfunction

    function automatic logic [31:0] route_to_word(input route_t r);
        return {r.to_pin, r.to_nmi, 24'b0, r.pin};
    endfunction

endpackage

// File: rtl/irqsc_line.sv
module irqsc_line (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol,
    input  logic trig,
    input  logic dual,
    input  logic sw_set,
    input  logic sw_clr,
    output logic pend
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
        logic latched;
    } line_t;

    line_t st_d, st_q;
    logic  rise, fall, hit;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
        rise      = st_q.sync & ~st_q.prev;
        fall      = ~st_q.sync & st_q.prev;
        hit       = trig & (dual ? (rise | fall) : (pol ? rise : fall));
        // a hardware or software set in the same cycle wins over a clear
        st_d.latched = (st_q.latched & ~sw_clr) | hit | sw_set;
        pend      = trig ? st_q.latched : (st_q.sync ~^ pol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_latch_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latched && !sw_clr) |=> st_q.latched);

    p_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> st_q.latched);

    p_dual_any_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && dual && (st_q.sync != st_q.prev)) |=> st_q.latched);

endmodule

// File: rtl/irqsc_regs.sv
module irqsc_regs
    import irqsc_pkg::*;
#(
    parameter int unsigned N_LINES = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  we,
    input  logic [BUS_AW-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    input  logic [N_LINES-1:0]    pend,
    output logic [N_LINES-1:0]    pol,
    output logic [N_LINES-1:0]    trig,
    output logic [N_LINES-1:0]    dual,
    output logic [N_LINES-1:0]    mask,
    output route_t [N_LINES-1:0]  route,
    output logic [N_LINES-1:0]    sw_set,
    output logic [N_LINES-1:0]    sw_clr
);

    typedef struct packed {
        logic [N_LINES-1:0]   pol;
        logic [N_LINES-1:0]   trig;
        logic [N_LINES-1:0]   dual;
        logic [N_LINES-1:0]   mask;
        route_t [N_LINES-1:0] route;
        logic [31:0]          rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr, rd;

    always_comb begin
        st_d   = st_q;
        sw_set = '0;
        sw_clr = '0;
        wr     = sel & we;
        rd     = sel & ~we;

        if (wr) begin
            unique case (addr)
                OFS_POL:  st_d.pol  = wdata[N_LINES-1:0];
                OFS_TRIG: st_d.trig = wdata[N_LINES-1:0];
                OFS_DUAL: st_d.dual = wdata[N_LINES-1:0];
                OFS_MCLR: st_d.mask = st_q.mask & ~wdata[N_LINES-1:0];
                OFS_MSET: st_d.mask = st_q.mask | wdata[N_LINES-1:0];
                OFS_SWEDGE: begin
                    for (int i = 0; i < N_LINES; i++) begin
                        if (wdata[7:0] == 8'(i)) begin
                            sw_set[i] = wdata[31];
                            sw_clr[i] = ~wdata[31];
                        end
                    end
                end
                default: begin
                    for (int i = 0; i < N_LINES; i++) begin
                        if (addr == OFS_ROUTE + BUS_AW'(4 * i))
                            st_d.route[i] = word_to_route(wdata);
                    end
                end
            endcase
        end

        if (rd) begin
            st_d.rdata = '0;
            unique case (addr)
                OFS_POL:  st_d.rdata = 32'(st_q.pol);
                OFS_TRIG: st_d.rdata = 32'(st_q.trig);
                OFS_DUAL: st_d.rdata = 32'(st_q.dual);
                OFS_MASK: st_d.rdata = 32'(st_q.mask);
                OFS_PEND: st_d.rdata = 32'(pend);
                default: begin
                    for (int i = 0; i < N_LINES; i++) begin
                        if (addr == OFS_ROUTE + BUS_AW'(4 * i))
                            st_d.rdata = route_to_word(st_q.route[i]);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign pol   = st_q.pol;
    assign trig  = st_q.trig;
    assign dual  = st_q.dual;
    assign mask  = st_q.mask;
    assign route = st_q.route;

    p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && addr == OFS_MCLR)
        |=> ((st_q.mask & $past(wdata[N_LINES-1:0])) == '0));

    p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && addr == OFS_MSET)
        |=> ((st_q.mask & $past(wdata[N_LINES-1:0])) == $past(wdata[N_LINES-1:0])));

    p_mask_untouched_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && we && (addr == OFS_MSET || addr == OFS_MCLR)) |=> $stable(st_q.mask));

    p_cmd_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_set | sw_clr));

endmodule

// File: rtl/irqsc_router.sv
module irqsc_router
    import irqsc_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned N_PINS  = 8
) (
    input  logic [N_LINES-1:0]   live,
    input  route_t [N_LINES-1:0] route,
    output logic [N_PINS-1:0]    pin_hit,
    output logic                 nmi_hit
);

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        always_comb begin
            pin_hit[p] = 1'b0;
            for (int i = 0; i < N_LINES; i++) begin
                if (live[i] && route[i].to_pin && route[i].pin == 6'(p))
                    pin_hit[p] = 1'b1;
            end
        end
    end

    always_comb begin
        nmi_hit = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (live[i] && route[i].to_nmi)
                nmi_hit = 1'b1;
        end
    end

endmodule

// File: rtl/irq_shared_ctrl.sv
module irq_shared_ctrl
    import irqsc_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned N_PINS  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [N_PINS-1:0]  irq_pin,
    output logic               irq_nmi
);

    typedef struct packed {
        logic [N_PINS-1:0] pins;
        logic              nmi;
    } out_t;

    logic [N_LINES-1:0]   pol, trig, dual, mask, sw_set, sw_clr, pend, live;
    route_t [N_LINES-1:0] route;
    logic [N_PINS-1:0]    pin_hit;
    logic                 nmi_hit;
    out_t                 out_d, out_q;

    irqsc_regs #(.N_LINES(N_LINES)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .pend   (pend),
        .pol    (pol),
        .trig   (trig),
        .dual   (dual),
        .mask   (mask),
        .route  (route),
        .sw_set (sw_set),
        .sw_clr (sw_clr)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        irqsc_line u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (irq_in[i]),
            .pol    (pol[i]),
            .trig   (trig[i]),
            .dual   (dual[i]),
            .sw_set (sw_set[i]),
            .sw_clr (sw_clr[i]),
            .pend   (pend[i])
        );
    end

    assign live = pend & mask;

    irqsc_router #(.N_LINES(N_LINES), .N_PINS(N_PINS)) u_router (
        .live    (live),
        .route   (route),
        .pin_hit (pin_hit),
        .nmi_hit (nmi_hit)
    );

    always_comb begin
        out_d      = out_q;
        out_d.pins = pin_hit;
        out_d.nmi  = nmi_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_pin = out_q.pins;
    assign irq_nmi = out_q.nmi;

    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> (irq_pin == '0 && !irq_nmi));

    p_nmi_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nmi |-> $past(|(pend & mask)));

    p_pin_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pin != '0) |-> $past(|(pend & mask)));

endmodule

// File: tb/tb_irq_shared_ctrl.sv
`timescale 1ns/100ps
module tb_irq_shared_ctrl;

    localparam int NL = 32;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] irq_pin;
    logic          irq_nmi;

    int tests = 0;
    int fails = 0;
    logic [31:0] m_mask = '0, m_pol = '0, m_trig = '0, m_dual = '0;

    always #2.5 clk = ~clk;

    irq_shared_ctrl #(.N_LINES(NL), .N_PINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pin(irq_pin), .irq_nmi(irq_nmi)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_sel = 1'b0; bus_we = 1'b0;
        if (a == 12'h380) m_mask = m_mask | d;
        if (a == 12'h300) m_mask = m_mask & ~d;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        step(1);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic cfg(input int line, input bit p, input bit t, input bit du, input logic [31:0] rw);
        m_pol[line] = p; m_trig[line] = t; m_dual[line] = du;
        wr(12'h100, m_pol);
        wr(12'h180, m_trig);
        wr(12'h200, m_dual);
        wr(12'h500 + 12'(4 * line), rw);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h400, v); check("R5 mask after reset", v, 32'h0);
        rd(12'h100, v); check("R6 polarity after reset", v, 32'h0);
        check("R7 pins after reset", 32'(irq_pin), 32'h0);
        check("R8 nmi after reset", 32'(irq_nmi), 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        cfg(3, 1'b1, 1'b0, 1'b0, 32'h8000_0002);
        wr(12'h380, 32'h1 << 3);
        step(1);
        check("R1 active-high idle", 32'(irq_pin[2]), 32'h0);
        irq_in[3] = 1'b1;
        step(2); check("R9 level not early", 32'(irq_pin[2]), 32'h0);
        step(1); check("R1 active-high asserted", 32'(irq_pin[2]), 32'h1);
        rd(12'h480, v); check("R6 pending bit 3", 32'(v[3]), 32'h1);
        irq_in[3] = 1'b0;
        step(3); check("R1 level follows input", 32'(irq_pin[2]), 32'h0);
        cfg(4, 1'b0, 1'b0, 1'b0, 32'h8000_0003);
        wr(12'h380, 32'h1 << 4);
        step(1); check("R1 active-low with input low", 32'(irq_pin[3]), 32'h1);
        irq_in[4] = 1'b1;
        step(3); check("R1 active-low released", 32'(irq_pin[3]), 32'h0);
    endtask

    task automatic t_edge();
        cfg(5, 1'b1, 1'b1, 1'b0, 32'h8000_0001);
        wr(12'h380, 32'h1 << 5);
        irq_in[5] = 1'b1;
        step(3); check("R9 edge not early", 32'(irq_pin[1]), 32'h0);
        step(1); check("R2 rising edge latched", 32'(irq_pin[1]), 32'h1);
        irq_in[5] = 1'b0;
        step(4); check("R9 edge stays latched", 32'(irq_pin[1]), 32'h1);
        wr(12'h280, 32'h0000_0005);
        step(1); check("R4 command clears line 5", 32'(irq_pin[1]), 32'h0);
        cfg(6, 1'b0, 1'b1, 1'b0, 32'h8000_0001);
        wr(12'h380, 32'h1 << 6);
        irq_in[6] = 1'b1;
        step(5); check("R2 falling mode ignores rise", 32'(irq_pin[1]), 32'h0);
        irq_in[6] = 1'b0;
        step(4); check("R2 falling edge latched", 32'(irq_pin[1]), 32'h1);
        wr(12'h280, 32'h0000_0006);
        step(1);
    endtask

    task automatic t_dual();
        cfg(7, 1'b0, 1'b1, 1'b1, 32'h8000_0000);
        wr(12'h380, 32'h1 << 7);
        irq_in[7] = 1'b1;
        step(4); check("R3 dual catches rise", 32'(irq_pin[0]), 32'h1);
        wr(12'h280, 32'h0000_0007);
        step(1); check("R3 cleared", 32'(irq_pin[0]), 32'h0);
        irq_in[7] = 1'b0;
        step(4); check("R3 dual catches fall", 32'(irq_pin[0]), 32'h1);
        wr(12'h280, 32'h0000_0007);
        step(1);
    endtask

    task automatic t_swedge();
        logic [31:0] p0, v;
        cfg(9, 1'b0, 1'b1, 1'b0, 32'h0);
        rd(12'h480, p0); check("R4 line 9 idle", 32'(p0[9]), 32'h0);
        wr(12'h280, 32'h8000_0009);
        rd(12'h480, v); check("R4 command sets line 9", 32'(v[9]), 32'h1);
        wr(12'h280, 32'h0000_0009);
        rd(12'h480, v); check("R4 command clears line 9", 32'(v[9]), 32'h0);
        wr(12'h280, 32'h8000_0028);
        rd(12'h480, v); check("R10 out-of-range line ignored", v, p0);
        wr(12'h480, 32'hFFFF_FFFF);
        wr(12'h400, 32'hFFFF_FFFF);
        rd(12'h400, v); check("R10 read-only writes ignored", v, m_mask);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(12'h380, 32'h0000_F000);
        rd(12'h400, v); check("R5 set mask", v, m_mask);
        wr(12'h300, 32'h0000_3000);
        rd(12'h400, v); check("R5 clear mask", v, m_mask);
        wr(12'h380, 32'h0);
        wr(12'h300, 32'h0);
        rd(12'h400, v); check("R5 zero writes no effect", v, m_mask);
        wr(12'h300, 32'h0000_F000);
        rd(12'h180, v); check("R6 trigger readback", v, m_trig);
    endtask

    task automatic t_nmi();
        cfg(10, 1'b0, 1'b1, 1'b0, 32'h4000_0000);
        wr(12'h380, 32'h1 << 10);
        wr(12'h280, 32'h8000_000A);
        check("R9 nmi one edge later", 32'(irq_nmi), 32'h0);
        step(1); check("R8 nmi asserted", 32'(irq_nmi), 32'h1);
        check("R8 no pin for nmi-only line", 32'(irq_pin), 32'h0);
        wr(12'h300, 32'h1 << 10);
        step(1); check("R5 mask blocks nmi", 32'(irq_nmi), 32'h0);
        wr(12'h380, 32'h1 << 10);
        step(1); check("R8 nmi back after unmask", 32'(irq_nmi), 32'h1);
        wr(12'h280, 32'h0000_000A);
        step(1);
    endtask

    task automatic t_route();
        logic [31:0] v;
        cfg(11, 1'b0, 1'b1, 1'b0, 32'h8000_003C);
        wr(12'h380, 32'h1 << 11);
        wr(12'h280, 32'h8000_000B);
        step(2); check("R7 pin number out of range", 32'(irq_pin), 32'h0);
        rd(12'h500 + 12'(4 * 11), v); check("R6 route readback", v, 32'h8000_003C);
        wr(12'h500 + 12'(4 * 11), 32'h8000_0005);
        step(1); check("R7 routed to pin 5", 32'(irq_pin), 32'h20);
        cfg(13, 1'b0, 1'b1, 1'b0, 32'h8000_0005);
        wr(12'h380, 32'h1 << 13);
        wr(12'h280, 32'h8000_000D);
        wr(12'h280, 32'h0000_000B);
        step(1); check("R7 OR of shared pin", 32'(irq_pin), 32'h20);
        wr(12'h280, 32'h0000_000D);
        step(1); check("R7 pin drops when all clear", 32'(irq_pin), 32'h0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_level();
        t_edge();
        t_dual();
        t_swedge();
        t_mask();
        t_nmi();
        t_route();
        step(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule